// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

The block gathers thirteen level-sensitive interrupt request lines, numbered 1 to 13, and presents one request at a time to the processor as a 3-bit priority level together with an 8-bit exception vector number. Each source owns an 8-bit control register. Bits [4:2] give the interrupt level and bits [1:0] a sub-priority within that level, so bits [4:0] together form a 5-bit arbitration key. Bit 7 chooses between an automatically formed vector and a programmed one. A mask register removes sources from arbitration, and a pending register mirrors the request lines.

Software reaches the registers over a simple single-cycle bus with a write strobe, an address, write data and combinational read data. The control register of source n sits at address n. The mask is at 0x10 and the read-only pending register at 0x11, with bit n standing for source n and bit 0 always reading 0. The software vector is at 0x12, the first serial-port vector at 0x13 and the second at 0x14. Writes to any other address have no effect.

A two-state presentation machine sits in front of the processor. In state QUIET it drives level 0 and vector 0. In state PRESENT it drives the registered winner. QUIET moves to PRESENT when arbitration finds a winner. PRESENT moves back to QUIET when no winner remains. PRESENT stays in PRESENT, refreshing level and vector, while a winner exists.

Top module: `picx_top`

## Requirements
- R1: Pending bit n is a copy of request line n taken at each clock edge. Reading address 0x11 returns it in bit n, with bit 0 reading 0.
- R2: A source takes part in arbitration only when its pending bit is 1 and its mask bit is 0. The mask resets to 0x3FFE, which masks every source.
- R3: The winner is the active source with the largest control[4:0]. On equal keys the lower-numbered source wins.
- R4: When the winner's control[4:0] is below 4, or no source is active, level and vector are both 0.
- R5: The level output equals control[4:2] of the winner.
- R6: When control bit 7 of the winner is 1, the vector is 24 plus the level.
- R7: When control bit 7 of the winner is 0, source 8 takes the software vector, source 12 the first serial-port vector and source 13 the second. Every other source yields 0x0F.
- R8: At reset the control registers of sources 1 to 8 hold 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C and 0x1C. Sources 9 to 11 hold 0x80 and sources 12 and 13 hold 0x00. All three vector registers hold 0x0F, the outputs are 0 and the machine is in QUIET.
- R9: A write to a control or vector register is read back from the same address on the next cycle. Control and vector registers keep data bits [7:0].
- R10: A change on a request line reaches level and vector on the second clock edge after it. A register write reaches them on the edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 13 | Request lines, bit n for source n |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| cpu_level | output | 3 | Presented interrupt level, 0 when none |
| cpu_vector | output | 8 | Presented vector number, 0 when none |

## Verification
A wrong pending or mask bit shows up as a wrong level or vector on the second edge after the stimulus. It also shows up at once in the pending readback. A corrupted control or vector register changes which source wins, or the vector formed for it, on the next edge after the write. The bench pairs request patterns that differ only by a tie, a mask bit or a vector selector, so that each of these faults moves the output to a distinct value.

// File: rtl/picx_pkg.sv
package picx_pkg;
    localparam int NUM_SRC   = 13;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int CTL_W     = 8;
    localparam int LVL_W     = 3;
    localparam int KEY_W     = 5;
    localparam int KEY_MIN   = 4;
    localparam int AUTO_BASE = 24;
    localparam int SRC_SWV   = 8;
    localparam int SRC_UVA   = 12;
    localparam int SRC_UVB   = 13;
    localparam logic [7:0] VEC_DEFAULT = 8'h0F;

    localparam logic [ADDR_W-1:0] A_MASK = 5'h10;
    localparam logic [ADDR_W-1:0] A_PEND = 5'h11;
    localparam logic [ADDR_W-1:0] A_SWV  = 5'h12;
    localparam logic [ADDR_W-1:0] A_UVA  = 5'h13;
    localparam logic [ADDR_W-1:0] A_UVB  = 5'h14;

    typedef enum logic [0:0] {
        ST_QUIET   = 1'b0,
        ST_PRESENT = 1'b1
    } pres_state_e;

    function automatic logic [7:0] ctl_reset(input int idx);
        if (idx <= 7)       return 8'(idx * 4);
        else if (idx == 8)  return 8'h1C;
        else if (idx <= 11) return 8'h80;
        else                return 8'h00;
    endfunction
endpackage

// File: rtl/picx_regs.sv
module picx_regs
    import picx_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N:1]          irq_in,
    input  logic                wr,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic [N:1]          pend,
    output logic [N:1]          mask,
    output logic [N:1][7:0]     ctl,
    output logic [7:0]          swv,
    output logic [7:0]          uva,
    output logic [7:0]          uvb
);
    // pending mirror of request lines
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= irq_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
            swv  <= VEC_DEFAULT;
            uva  <= VEC_DEFAULT;
            uvb  <= VEC_DEFAULT;
        end else if (wr) begin
            if (addr == A_MASK) mask <= wdata[N:1];
            if (addr == A_SWV)  swv  <= wdata[7:0];
            if (addr == A_UVA)  uva  <= wdata[7:0];
            if (addr == A_UVB)  uvb  <= wdata[7:0];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 1; i <= N; i++) begin
            if (!rst_n)
                ctl[i] <= ctl_reset(i);
            else if (wr && addr == AW'(i))
                ctl[i] <= wdata[7:0];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 1; i <= N; i++) begin
            if (addr == AW'(i)) rdata = DW'(ctl[i]);
        end
        unique case (addr)
            A_MASK:  rdata = DW'({mask, 1'b0});
            A_PEND:  rdata = DW'({pend, 1'b0});
            A_SWV:   rdata = DW'(swv);
            A_UVA:   rdata = DW'(uva);
            A_UVB:   rdata = DW'(uvb);
            default: ;
        endcase
    end

    p_pend_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend == $past(irq_in));

    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == A_MASK) |=> $stable(mask));
endmodule

// File: rtl/picx_arbiter.sv
module picx_arbiter
    import picx_pkg::*;
#(
    parameter int N    = NUM_SRC,
    parameter int KW   = KEY_W,
    localparam int IDW = $clog2(N + 1)
) (
    input  logic [N:1]       active,
    input  logic [N:1][7:0]  ctl,
    output logic [N:1]       grant,
    output logic [IDW-1:0]   win_id,
    output logic [KW-1:0]    win_key,
    output logic [7:0]       win_ctl
);
    always_comb begin
        win_key = '0;
        win_id  = '0;
        win_ctl = '0;
        // strict compare keeps the lowest-numbered source on ties
        for (int i = 1; i <= N; i++) begin
            if (active[i] && (ctl[i][KW-1:0] > win_key)) begin
                win_key = ctl[i][KW-1:0];
                win_id  = IDW'(i);
                win_ctl = ctl[i];
            end
        end
    end

    for (genvar g = 1; g <= N; g++) begin : g_grant
        assign grant[g] = (win_id == IDW'(g));
    end

    always_comb begin
        p_grant_onehot_r3: assert ($onehot0(grant));
        p_grant_active_r2: assert ((grant & ~active) == '0);
    end
endmodule

// File: rtl/picx_vector.sv
module picx_vector
    import picx_pkg::*;
#(
    parameter int N    = NUM_SRC,
    parameter int KW   = KEY_W,
    parameter int LW   = LVL_W,
    localparam int IDW = $clog2(N + 1)
) (
    input  logic [IDW-1:0] win_id,
    input  logic [KW-1:0]  win_key,
    input  logic [7:0]     win_ctl,
    input  logic [7:0]     swv,
    input  logic [7:0]     uva,
    input  logic [7:0]     uvb,
    output logic           nxt_valid,
    output logic [LW-1:0]  nxt_level,
    output logic [7:0]     nxt_vec
);
    always_comb begin
        nxt_valid = (win_key >= KW'(KEY_MIN));
        nxt_level = '0;
        nxt_vec   = '0;
        if (nxt_valid) begin
            nxt_level = win_ctl[2 +: LW];
            if (win_ctl[7]) begin
                nxt_vec = 8'(AUTO_BASE) + 8'(nxt_level);
            end else if (win_id == IDW'(SRC_SWV)) begin
                nxt_vec = swv;
            end else if (win_id == IDW'(SRC_UVA)) begin
                nxt_vec = uva;
            end else if (win_id == IDW'(SRC_UVB)) begin
                nxt_vec = uvb;
            end else begin
                nxt_vec = VEC_DEFAULT;
            end
        end
    end
endmodule

// File: rtl/picx_top.sv
module picx_top
    import picx_pkg::*;
#(
    parameter int N    = NUM_SRC,
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W,
    parameter int LW   = LVL_W,
    localparam int IDW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N:1]    irq_in,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [LW-1:0] cpu_level,
    output logic [7:0]    cpu_vector
);
    logic [N:1]      pend, mask, active, grant;
    logic [N:1][7:0] ctl;
    logic [7:0]      swv, uva, uvb, win_ctl, nxt_vec;
    logic [IDW-1:0]  win_id;
    logic [KEY_W-1:0] win_key;
    logic            nxt_valid;
    logic [LW-1:0]   nxt_level;
    pres_state_e     state_q, state_d;

    picx_regs #(.N(N), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .pend(pend), .mask(mask), .ctl(ctl),
        .swv(swv), .uva(uva), .uvb(uvb)
    );

    assign active = pend & ~mask;

    picx_arbiter #(.N(N), .KW(KEY_W)) u_arb (
        .active(active), .ctl(ctl), .grant(grant),
        .win_id(win_id), .win_key(win_key), .win_ctl(win_ctl)
    );

    picx_vector #(.N(N), .KW(KEY_W), .LW(LW)) u_vec (
        .win_id(win_id), .win_key(win_key), .win_ctl(win_ctl),
        .swv(swv), .uva(uva), .uvb(uvb),
        .nxt_valid(nxt_valid), .nxt_level(nxt_level), .nxt_vec(nxt_vec)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:   if (nxt_valid)  state_d = ST_PRESENT;
            ST_PRESENT: if (!nxt_valid) state_d = ST_QUIET;
            default:    state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_level  <= '0;
            cpu_vector <= '0;
        end else begin
            unique case (state_d)
                ST_PRESENT: begin
                    cpu_level  <= nxt_level;
                    cpu_vector <= nxt_vec;
                end
                default: begin
                    cpu_level  <= '0;
                    cpu_vector <= '0;
                end
            endcase
        end
    end

    p_quiet_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_QUIET |-> (cpu_level == '0 && cpu_vector == '0));

    p_present_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PRESENT |-> cpu_level != '0);
endmodule

// File: tb/tb_picx_top.sv
module tb_picx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:1] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  cpu_level;
    logic [7:0]  cpu_vector;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    picx_top dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_level(cpu_level), .cpu_vector(cpu_vector)
    );

    // {mask[13:0], request[13:0] (bit n = source n), level, vector}
    localparam logic [38:0] TBL [0:9] = '{
        {14'h0000, 14'h0002, 3'd1, 8'h0F},  // R3 single source
        {14'h0000, 14'h000A, 3'd3, 8'h0F},  // R3 higher key wins
        {14'h0000, 14'h0180, 3'd7, 8'h0F},  // R3 tie: 7 beats 8
        {14'h0000, 14'h0100, 3'd7, 8'h40},  // R7 software vector
        {14'h0000, 14'h0200, 3'd0, 8'h00},  // R4 key below 4
        {14'h0100, 14'h0104, 3'd2, 8'h0F},  // R2 masked source skipped
        {14'h3FFE, 14'h3FFE, 3'd0, 8'h00},  // R2 all masked
        {14'h0000, 14'h3000, 3'd0, 8'h00},  // R4 zero keys
        {14'h0008, 14'h0018, 3'd4, 8'h0F},  // R2 mask picks next
        {14'h0000, 14'h0060, 3'd6, 8'h0F}   // R5 level field
    };

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        tests++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr %h: got %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic out_chk(input logic [2:0] lv, input logic [7:0] vc, input string tag);
        tests++;
        if (cpu_level !== lv || cpu_vector !== vc) begin
            fails++;
            $display("FAIL %s: got level %0d vector %h expected level %0d vector %h",
                     tag, cpu_level, cpu_vector, lv, vc);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] exp_ctl(input int i);
        if (i <= 7)       return 8'(i * 4);
        else if (i == 8)  return 8'h1C;
        else if (i <= 11) return 8'h80;
        else              return 8'h00;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        out_chk(3'd0, 8'h00, "R8 reset outputs");
        rd_chk(5'h10, 16'h3FFE, "R2 R8 reset mask");
        rd_chk(5'h11, 16'h0000, "R1 reset pending");
        rd_chk(5'h12, 16'h000F, "R8 reset sw vector");
        rd_chk(5'h13, 16'h000F, "R8 reset vector A");
        rd_chk(5'h14, 16'h000F, "R8 reset vector B");
        for (int i = 1; i <= 13; i++)
            rd_chk(5'(i), 16'(exp_ctl(i)), "R8 reset control");

        // R2 masked at reset: request present, nothing shown
        @(negedge clk); irq_in = 13'h0001;
        settle();
        out_chk(3'd0, 8'h00, "R2 reset mask blocks");
        irq_in = '0;

        wr_reg(5'h12, 16'h0040);
        wr_reg(5'h13, 16'h0050);
        wr_reg(5'h14, 16'h0060);
        rd_chk(5'h12, 16'h0040, "R9 sw vector readback");

        for (int k = 0; k < 10; k++) begin
            wr_reg(5'h10, 16'(TBL[k][38:25]));
            @(negedge clk);
            irq_in = TBL[k][24:12];
            settle();
            out_chk(TBL[k][10:8], TBL[k][7:0], "R2 R3 R4 R5 R7 table");
            irq_in = '0;
        end
        wr_reg(5'h10, 16'h0000);
        settle();

        // R10 request latency, R1 pending readback
        @(negedge clk); irq_in = 13'h0020;   // source 6
        @(posedge clk); @(negedge clk);
        out_chk(3'd0, 8'h00, "R10 one edge after request");
        @(posedge clk); @(negedge clk);
        out_chk(3'd6, 8'h0F, "R10 two edges after request");
        rd_chk(5'h11, 16'h0040, "R1 pending readback");

        // R10 write latency
        wr_reg(5'h10, 16'h0040);
        out_chk(3'd6, 8'h0F, "R10 on write edge");
        @(posedge clk); @(negedge clk);
        out_chk(3'd0, 8'h00, "R10 edge after write");
        irq_in = '0;
        wr_reg(5'h10, 16'h0000);

        // R6 autovector
        wr_reg(5'd9, 16'h0098);
        @(negedge clk); irq_in = 13'h0100;   // source 9
        settle();
        out_chk(3'd6, 8'h1E, "R6 autovector");
        irq_in = '0;

        // R7 serial-port vectors, R3 sub-priority
        wr_reg(5'd12, 16'h0014);
        @(negedge clk); irq_in = 13'h0800;   // source 12
        settle();
        out_chk(3'd5, 8'h50, "R7 vector A");
        wr_reg(5'd13, 16'h0015);
        @(negedge clk); irq_in = 13'h1800;   // sources 12 and 13
        settle();
        out_chk(3'd5, 8'h60, "R3 R7 sub-priority vector B");
        irq_in = '0;

        // R4 key below 4 with nonzero control
        wr_reg(5'd5, 16'h0003);
        @(negedge clk); irq_in = 13'h0010;   // source 5
        settle();
        out_chk(3'd0, 8'h00, "R4 key 3 not presented");
        irq_in = '0;

        // R5 R9 full key
        wr_reg(5'd2, 16'hFF1F);
        rd_chk(5'd2, 16'h001F, "R9 control readback");
        @(negedge clk); irq_in = 13'h0002;   // source 2
        settle();
        out_chk(3'd7, 8'h0F, "R5 level from control");
        irq_in = '0;
        settle();
        out_chk(3'd0, 8'h00, "R4 release returns quiet");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule